// File: doc/BRIEF.md
# Dual-Mode Serial Frame Transmitter

This block turns one character into a serial frame on a single output line. The host sets a data word, a data length, a parity choice, a stop-bit count and a line-coding choice, then pulses a start strobe. The block takes a copy of all these settings when it accepts the strobe, so the host may change its inputs while the frame is going out.

A frame is a start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. Each bit lasts two pulses of a half-bit enable input, which a baud generator outside the block provides. The line is either plain level (NRZ) coding, with the level held for the whole bit, or Manchester bi-phase coding, where every bit has a transition at its centre. Parity is never inserted when Manchester coding is selected.

The block raises `busy` for the whole frame and gives a one-cycle `done` pulse when the frame ends. Between frames the line rests high.

Top module: `dmsf_tx`

## Requirements
- R1: When `rst` is high at a clock edge, the block returns to idle: `line_out` = 1, `busy` = 0 and `done` = 0. In idle, pulses on `tick` leave all three outputs unchanged.
- R2: A `start` pulse while `busy` = 0 is accepted at the clock edge. `busy` is 1 from the next cycle, and all configuration inputs are copied at that edge. A `start` pulse while `busy` = 1 is ignored, and so is any change to the configuration inputs during a frame.
- R3: The frame begins with a start bit of value 0. The data bits follow, least significant bit first. `nbits_in` gives the data length as a plain count from 5 to 9. A count below 5 is sent as 5 and a count above 9 is sent as 9.
- R4: `par_in` = 2'b01 selects even parity, where the parity bit is the XOR of the data bits that are sent. `par_in` = 2'b10 selects odd parity, which is that XOR inverted. `par_in` = 2'b00 and 2'b11 insert no parity bit. When present, the parity bit goes after the last data bit and before the first stop bit.
- R5: `two_stop_in` = 0 ends the frame with one stop bit of value 1, and `two_stop_in` = 1 ends it with two.
- R6: Each bit spans two `tick` pulses, one for each half-bit. The line changes only in the cycle after a `tick` pulse. In NRZ coding (`manch_in` = 0) the line carries the bit value in both halves.
- R7: In Manchester coding (`manch_in` = 1), every bit is encoded, including the start and stop bits. A 1 is sent as low in the first half and high in the second. A 0 is sent as high in the first half and low in the second.
- R8: In Manchester coding no parity bit is sent, whatever the value of `par_in`.
- R9: `busy` falls in the cycle after the `tick` that ends the second half of the last stop bit. `done` is 1 in that same cycle only. `line_out` is 1 whenever `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-bit enable, one cycle wide |
| start | input | 1 | Start strobe |
| data_in | input | 9 | Character to send, least significant bit first |
| nbits_in | input | 4 | Data length as a count (5..9, clamped) |
| par_in | input | 2 | Parity: 01 even, 10 odd, 00/11 none |
| two_stop_in | input | 1 | 1 selects two stop bits |
| manch_in | input | 1 | 1 selects Manchester coding, 0 selects NRZ |
| line_out | output | 1 | Serial line |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The embedded assertions check on every cycle:
- a Manchester bit always changes level at its centre, and an NRZ bit never does;
- the half-bit phase moves only on a `tick`;
- the data index stays inside the copied length;
- no parity phase is entered in Manchester coding;
- the copied settings stay fixed while busy;
- `busy` falls exactly with `done`, and the line is high whenever the block is idle.

Only the bench scenarios can show the exact half-bit sequence of each frame. That covers the LSB-first bit order, the parity value and where it sits, the clamping of the data length, the stop-bit count, and that a second strobe during a frame does not change what is sent.

// File: rtl/dmsf_pkg.sv
package dmsf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        PSEL_NONE = 2'b00,
        PSEL_EVEN = 2'b01,
        PSEL_ODD  = 2'b10,
        PSEL_RSVD = 2'b11
    } psel_e;

    typedef struct packed {
        logic manch;
        logic two_stop;
        logic par_en;
        logic par_odd;
    } frame_cfg_t;

    // Parity is inserted only for a real parity choice in level coding.
    function automatic logic parity_active(input logic [1:0] psel, input logic manch);
        return ((psel == PSEL_EVEN) || (psel == PSEL_ODD)) && !manch;
    endfunction

    // Line level for one half of a bit.
    function automatic logic half_level(input logic bitv, input logic second, input logic manch);
        if (manch)
            return second ? bitv : ~bitv;
        return bitv;
    endfunction

endpackage

// File: rtl/dmsf_parity.sv
module dmsf_parity #(
    parameter int W    = 9,
    parameter int NB_W = 4
) (
    input  logic [W-1:0]    data,
    input  logic [NB_W-1:0] nbits,
    input  logic            odd,
    output logic            par
);
    logic [W-1:0] mask;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_mask
            assign mask[gi] = (nbits > NB_W'(gi));
        end
    endgenerate

    assign par = (^(data & mask)) ^ odd;
endmodule

// File: rtl/dmsf_seq.sv
module dmsf_seq
    import dmsf_pkg::*;
#(
    parameter int W     = 9,
    parameter int W_MIN = 5,
    parameter int NB_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            start,
    input  logic [W-1:0]    data_in,
    input  logic [NB_W-1:0] nbits_in,
    input  logic [1:0]      par_in,
    input  logic            two_stop_in,
    input  logic            manch_in,
    input  logic            par_bit,
    output logic [W-1:0]    data_q,
    output logic [NB_W-1:0] nbits_q,
    output logic            par_odd_q,
    output logic            manch_q,
    output logic            cur_bit,
    output logic            half,
    output logic            busy,
    output logic            done
);
    localparam logic [NB_W-1:0] NB_MAX = NB_W'(W);
    localparam logic [NB_W-1:0] NB_MIN = NB_W'(W_MIN);
    localparam logic [NB_W-1:0] NB_ONE = NB_W'(1);

    phase_e          phase;
    frame_cfg_t      cfg_q;
    logic [NB_W-1:0] idx;
    logic            stop_second;
    logic [NB_W-1:0] nbits_clamped;

    always_comb begin
        if (nbits_in < NB_MIN)
            nbits_clamped = NB_MIN;
        else if (nbits_in > NB_MAX)
            nbits_clamped = NB_MAX;
        else
            nbits_clamped = nbits_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cfg_q       <= '0;
            data_q      <= '0;
            nbits_q     <= NB_MIN;
            idx         <= '0;
            half        <= 1'b0;
            stop_second <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    data_q         <= data_in;
                    nbits_q        <= nbits_clamped;
                    cfg_q.manch    <= manch_in;
                    cfg_q.two_stop <= two_stop_in;
                    cfg_q.par_en   <= parity_active(par_in, manch_in);
                    cfg_q.par_odd  <= (par_in == PSEL_ODD);
                    phase          <= PH_START;
                    half           <= 1'b0;
                    idx            <= '0;
                    stop_second    <= 1'b0;
                end
            end else if (tick) begin
                if (!half) begin
                    half <= 1'b1;
                end else begin
                    half <= 1'b0;
                    unique case (phase)
                        PH_START: begin
                            phase <= PH_DATA;
                            idx   <= '0;
                        end
                        PH_DATA: begin
                            if (idx == nbits_q - NB_ONE)
                                phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
                            else
                                idx <= idx + NB_ONE;
                        end
                        PH_PAR: phase <= PH_STOP;
                        PH_STOP: begin
                            if (cfg_q.two_stop && !stop_second) begin
                                stop_second <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                            end
                        end
                        default: phase <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        unique case (phase)
            PH_START: cur_bit = 1'b0;
            PH_DATA:  cur_bit = data_q[idx];
            PH_PAR:   cur_bit = par_bit;
            default:  cur_bit = 1'b1;
        endcase
    end

    assign busy      = (phase != PH_IDLE);
    assign manch_q   = cfg_q.manch;
    assign par_odd_q = cfg_q.par_odd;

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(data_q) && $stable(cfg_q) && $stable(nbits_q)));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (idx < nbits_q));

    assert_half_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(half));

    assert_no_par_manch_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAR) |-> !cfg_q.manch);

    assert_done_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: rtl/dmsf_enc.sv
module dmsf_enc
    import dmsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic manch,
    input  logic half,
    input  logic bitv,
    output logic line
);
    assign line = busy ? half_level(bitv, half, manch) : 1'b1;

    assert_manch_mid_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && manch && half && !$past(half)) |-> (line != $past(line)));

    assert_nrz_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !manch && half && !$past(half)) |-> $stable(line));

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line);
endmodule

// File: rtl/dmsf_tx.sv
module dmsf_tx #(
    parameter int DATA_MAX = 9,
    parameter int DATA_MIN = 5,
    localparam int NB_W    = $clog2(DATA_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                start,
    input  logic [DATA_MAX-1:0] data_in,
    input  logic [NB_W-1:0]     nbits_in,
    input  logic [1:0]          par_in,
    input  logic                two_stop_in,
    input  logic                manch_in,
    output logic                line_out,
    output logic                busy,
    output logic                done
);
    logic [DATA_MAX-1:0] data_q;
    logic [NB_W-1:0]     nbits_q;
    logic                par_odd_q;
    logic                manch_q;
    logic                cur_bit;
    logic                half;
    logic                par_bit;

    dmsf_seq #(.W(DATA_MAX), .W_MIN(DATA_MIN), .NB_W(NB_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start       (start),
        .data_in     (data_in),
        .nbits_in    (nbits_in),
        .par_in      (par_in),
        .two_stop_in (two_stop_in),
        .manch_in    (manch_in),
        .par_bit     (par_bit),
        .data_q      (data_q),
        .nbits_q     (nbits_q),
        .par_odd_q   (par_odd_q),
        .manch_q     (manch_q),
        .cur_bit     (cur_bit),
        .half        (half),
        .busy        (busy),
        .done        (done)
    );

    dmsf_parity #(.W(DATA_MAX), .NB_W(NB_W)) u_par (
        .data  (data_q),
        .nbits (nbits_q),
        .odd   (par_odd_q),
        .par   (par_bit)
    );

    dmsf_enc u_enc (
        .clk   (clk),
        .rst   (rst),
        .busy  (busy),
        .manch (manch_q),
        .half  (half),
        .bitv  (cur_bit),
        .line  (line_out)
    );
endmodule

// File: tb/tb_dmsf_tx.sv
`timescale 1ns/1ps
module tb_dmsf_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic [8:0] data_in = '0;
    logic [3:0] nbits_in = 4'd8;
    logic [1:0] par_in = 2'b00;
    logic       two_stop_in = 1'b0;
    logic       manch_in = 1'b0;
    logic       line_out, busy, done;

    int total = 0;
    int fails = 0;

    dmsf_tx dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start),
        .data_in(data_in), .nbits_in(nbits_in), .par_in(par_in),
        .two_stop_in(two_stop_in), .manch_in(manch_in),
        .line_out(line_out), .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    // half-bit enable: one cycle high out of every four
    initial begin
        forever begin
            repeat (3) begin
                @(posedge clk); #1 tick = 1'b0;
            end
            @(posedge clk); #1 tick = 1'b1;
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic test_reset_idle();
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(line_out == 1'b1, "R1 idle line", line_out, 1);
            check(busy == 1'b0 && done == 1'b0, "R1 idle busy/done", {busy, done}, 0);
        end
    endtask

    task automatic send(input logic [8:0] d, input int nb, input logic [1:0] pm,
                        input bit two, input bit mc, input bit disturb, input string tag);
        logic exp_b[0:15];
        int   n = 0;
        int   eff;
        logic p = 1'b0;
        eff = (nb < 5) ? 5 : ((nb > 9) ? 9 : nb);
        exp_b[n] = 1'b0; n++;
        for (int i = 0; i < eff; i++) begin
            exp_b[n] = d[i]; n++;
            p ^= d[i];
        end
        if (pm == 2'b10) p = ~p;
        if ((pm == 2'b01 || pm == 2'b10) && !mc) begin
            exp_b[n] = p; n++;
        end
        exp_b[n] = 1'b1; n++;
        if (two) begin
            exp_b[n] = 1'b1; n++;
        end

        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk); #1;
        start = 1'b1; data_in = d; nbits_in = 4'(nb); par_in = pm;
        two_stop_in = two; manch_in = mc;
        @(posedge clk); #1;
        start = disturb;
        data_in = ~d; nbits_in = 4'(eff == 9 ? 5 : 9); par_in = ~pm;
        two_stop_in = ~two; manch_in = ~mc;
        fork
            begin
                @(posedge clk); #1 start = 1'b0;
            end
        join_none
        for (int k = 0; k < 2 * n; k++) begin
            logic e;
            e = mc ? ((k % 2) ? exp_b[k/2] : ~exp_b[k/2]) : exp_b[k/2];
            @(negedge clk);
            while (!tick) @(negedge clk);
            check(line_out == e, $sformatf("%s half %0d", tag, k), line_out, e);
            check(busy == 1'b1, $sformatf("R9 busy in frame %s", tag), busy, 1);
        end
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, $sformatf("R9 end of frame %s", tag), {done, busy}, 2);
        check(line_out == 1'b1, $sformatf("R9 idle line %s", tag), line_out, 1);
        @(negedge clk);
        check(done == 1'b0, $sformatf("R9 done one cycle %s", tag), done, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(line_out == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 in reset",
              {line_out, busy, done}, 4);
        @(posedge clk); #1 rst = 1'b0;
        test_reset_idle();
        send(9'h0A5, 8, 2'b00, 1'b0, 1'b0, 1'b0, "R3 R6 nrz 8N1");
        send(9'h013, 5, 2'b01, 1'b1, 1'b0, 1'b0, "R4 R5 nrz 5E2");
        send(9'h1C6, 9, 2'b10, 1'b0, 1'b0, 1'b0, "R4 nrz 9O1");
        send(9'h06B, 7, 2'b11, 1'b0, 1'b0, 1'b0, "R4 nrz 7 par11 none");
        send(9'h1FF, 3, 2'b01, 1'b0, 1'b0, 1'b0, "R3 clamp low");
        send(9'h155, 12, 2'b10, 1'b0, 1'b0, 1'b0, "R3 clamp high");
        send(9'h0B2, 8, 2'b00, 1'b0, 1'b0, 1'b1, "R2 start ignored busy");
        send(9'h0C9, 8, 2'b01, 1'b0, 1'b1, 1'b0, "R7 R8 manch even req");
        send(9'h035, 6, 2'b10, 1'b1, 1'b1, 1'b1, "R7 R8 R5 manch odd req two stop");
        test_reset_idle();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule